// File: doc/BRIEF.md
# Alternate Bus Master Arbitration Requester

This block sits inside a device that needs to borrow a processor's address and data buses for a transfer of its own. While the device's local request is high, the block drives an active-low bus request toward the processor. It then waits for the processor's active-low grant. A grant alone does not give it the bus. The block takes the bus only when it sees four things at once: the grant is active, the processor's address strobe is idle, no transfer acknowledge is being driven, and no other master is holding its own grant acknowledge. When those hold, it drives its own active-low acknowledge, which claims the bus.

The block owns the bus until the local request falls. It then spends one cycle releasing the bus and returns to idle. A hold-off counter keeps it from asking for the bus again straight away. Each of the four bus-side inputs is asynchronous, so each one passes through a synchronizer chain before the block decides anything on it. The owner flag tells the local transfer engine when the bus is its to drive.

Top module: `altm_arbiter`

## Requirements
- R1: During and right after reset, bus_req_n and bus_ack_n are high (inactive) and owner is 0.
- R2: When job_req is high in the idle state with no hold-off pending, bus_req_n goes low at the next clock edge, and bus_ack_n stays high.
- R3: While the synchronized grant_n is high (inactive), bus_ack_n is never driven low, however long the request waits.
- R4: While the synchronized addr_strobe_n is low (processor cycle in progress), bus_ack_n is never driven low, even when the grant is active.
- R5: While the synchronized xfer_ack_n or rival_ack_n is low, bus_ack_n is never driven low.
- R6: Every bus input reaches the decision logic through SYNC_STAGES flops. With the default of 2, the claim behaves as follows. If the last busy input goes inactive while the block is waiting with the grant already seen, bus_ack_n falls at the third clock edge after that change. If grant_n falls while the block is requesting on an otherwise free bus, bus_ack_n falls at the fourth edge.
- R7: bus_req_n stays low for exactly the first clock cycle in which bus_ack_n is low, and is high from the next cycle on. bus_ack_n then stays low and owner stays 1 while job_req is high, even after grant_n returns high.
- R8: When job_req is sampled low while owning the bus, the next clock edge drives bus_ack_n high and owner to 0, and bus_req_n stays high.
- R9: After a release, bus_req_n stays high for HOLDOFF_CYCLES+2 clock cycles even if job_req is held high. With the default of 1, that is 3 cycles. It then goes low again.
- R10: If job_req falls while the block is still requesting or waiting for a free bus, bus_req_n returns high at the next clock edge and bus_ack_n is never driven low.
- R11: owner is 1 exactly in the cycles where bus_ack_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| job_req | input | 1 | Local request to hold the bus; high for the whole transfer job |
| grant_n | input | 1 | Bus grant from the processor, active low, asynchronous |
| addr_strobe_n | input | 1 | Processor address strobe, active low, asynchronous |
| xfer_ack_n | input | 1 | Data transfer acknowledge on the bus, active low, asynchronous |
| rival_ack_n | input | 1 | Grant acknowledge held by any other master, active low, asynchronous |
| bus_req_n | output | 1 | Bus request toward the processor, active low |
| bus_ack_n | output | 1 | This block's grant acknowledge, active low; low while it owns the bus |
| owner | output | 1 | High while this block owns the bus |

## Verification
The bench builds the block with its default parameters: SYNC_STAGES of 2 and HOLDOFF_CYCLES of 1. With these values every latency stays short enough to count exactly: three edges from the last busy input clearing to the claim, four edges from the grant arriving to the claim, and a three-cycle quiet gap after a release. Each busy condition is held for many cycles and then cleared alone, which exercises every term of the idle check one at a time. Withdrawing the request before the claim covers the abandon paths from both waiting states.

// File: rtl/altm_pkg.sv
package altm_pkg;

    // Arbitration sequencer states
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REQ      = 3'd1,
        ST_WAITFREE = 3'd2,
        ST_OWN      = 3'd3,
        ST_REL      = 3'd4
    } arb_state_e;

    // Raw view of the shared bus, all signals active low
    typedef struct packed {
        logic grant_n;
        logic strobe_n;
        logic dack_n;
        logic rival_n;
    } bus_view_t;

    localparam int unsigned BUS_VIEW_W = $bits(bus_view_t);
    localparam bus_view_t   BUS_QUIET  = '{grant_n: 1'b1, strobe_n: 1'b1, dack_n: 1'b1, rival_n: 1'b1};

    // The bus may be claimed only when granted and nobody else is using it
    function automatic logic view_is_free(input bus_view_t v);
        return !v.grant_n && v.strobe_n && v.dack_n && v.rival_n;
    endfunction

    function automatic logic view_is_granted(input bus_view_t v);
        return !v.grant_n;
    endfunction

endpackage

// File: rtl/altm_sync.sv
module altm_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/altm_free_check.sv
module altm_free_check
    import altm_pkg::*;
(
    input  bus_view_t view,
    output logic      granted,
    output logic      free
);
    assign granted = view_is_granted(view);
    assign free    = view_is_free(view);
endmodule

// File: rtl/altm_fsm.sv
module altm_fsm
    import altm_pkg::*;
#(
    parameter int unsigned HOLDOFF_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic job_req,
    input  logic granted,
    input  logic free,
    output logic bus_req_n,
    output logic bus_ack_n,
    output logic owner
);
    localparam int unsigned CW = (HOLDOFF_CYCLES < 1) ? 1 : $clog2(HOLDOFF_CYCLES + 1);

    arb_state_e     state, nxt;
    logic           own_first;
    logic [CW-1:0]  hold_cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (job_req && hold_cnt == '0) nxt = ST_REQ;
            ST_REQ:      if (!job_req) nxt = ST_IDLE;
                         else if (granted) nxt = ST_WAITFREE;
            ST_WAITFREE: if (!job_req) nxt = ST_IDLE;
                         else if (free) nxt = ST_OWN;
            ST_OWN:      if (!job_req) nxt = ST_REL;
            ST_REL:      nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            own_first <= 1'b0;
            hold_cnt  <= '0;
        end else begin
            state     <= nxt;
            own_first <= (nxt == ST_OWN) && (state != ST_OWN);
            if (state == ST_REL)
                hold_cnt <= CW'(HOLDOFF_CYCLES);
            else if (state == ST_IDLE && hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign owner     = (state == ST_OWN);
    assign bus_ack_n = !owner;
    assign bus_req_n = !((state == ST_REQ) || (state == ST_WAITFREE) || own_first);

    // R4 / R5: the claim only follows a cycle in which the bus looked free
    p_claim_needs_free_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ack_n) |-> $past(free));

    // R3: no ownership reached straight from a request without a grant
    p_no_grant_no_own_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REQ && !granted) |=> (state != ST_OWN));

    // R7: request withdrawn after the first owned cycle
    p_req_drop_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_ack_n && $past(!bus_ack_n)) |-> bus_req_n);

    // R8: a dropped job releases the bus on the next edge
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (owner && !job_req) |=> (bus_ack_n && !owner && bus_req_n));

    // R2: a request is raised only when asked for
    p_req_needs_job_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req_n) |-> $past(job_req));

    // R9: no request in the cycle following a release
    p_holdoff_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(owner) |=> bus_req_n);

endmodule

// File: rtl/altm_arbiter.sv
module altm_arbiter
    import altm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned HOLDOFF_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic job_req,
    input  logic grant_n,
    input  logic addr_strobe_n,
    input  logic xfer_ack_n,
    input  logic rival_ack_n,
    output logic bus_req_n,
    output logic bus_ack_n,
    output logic owner
);
    bus_view_t                raw_view, safe_view;
    logic [BUS_VIEW_W-1:0]    safe_bits;
    logic                     granted, free;

    assign raw_view = '{grant_n: grant_n, strobe_n: addr_strobe_n,
                        dack_n: xfer_ack_n, rival_n: rival_ack_n};

    altm_sync #(
        .WIDTH   (BUS_VIEW_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_QUIET)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_view),
        .q   (safe_bits)
    );

    assign safe_view = bus_view_t'(safe_bits);

    altm_free_check u_free (
        .view    (safe_view),
        .granted (granted),
        .free    (free)
    );

    altm_fsm #(
        .HOLDOFF_CYCLES (HOLDOFF_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .job_req   (job_req),
        .granted   (granted),
        .free      (free),
        .bus_req_n (bus_req_n),
        .bus_ack_n (bus_ack_n),
        .owner     (owner)
    );

    // R11: the owner flag and the acknowledge never disagree
    p_owner_ack_r11: assert property (@(posedge clk) disable iff (rst)
        owner != bus_ack_n);

endmodule

// File: tb/test_altm_arbiter.sv
module test_altm_arbiter;
    logic clk = 1'b0;
    logic rst;
    logic job_req, grant_n, addr_strobe_n, xfer_ack_n, rival_ack_n;
    logic bus_req_n, bus_ack_n, owner;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    altm_arbiter i_altm_arbiter (
        .clk           (clk),
        .rst           (rst),
        .job_req       (job_req),
        .grant_n       (grant_n),
        .addr_strobe_n (addr_strobe_n),
        .xfer_ack_n    (xfer_ack_n),
        .rival_ack_n   (rival_ack_n),
        .bus_req_n     (bus_req_n),
        .bus_ack_n     (bus_ack_n),
        .owner         (owner)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {req_n,ack_n,owner} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] outs();
        return {bus_req_n, bus_ack_n, owner};
    endfunction

    task automatic quiet_bus();
        job_req = 1'b0; grant_n = 1'b1; addr_strobe_n = 1'b1;
        xfer_ack_n = 1'b1; rival_ack_n = 1'b1;
        tick(6);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        job_req = 1'b1; grant_n = 1'b0; addr_strobe_n = 1'b1;
        xfer_ack_n = 1'b1; rival_ack_n = 1'b1;
        tick(3);
        check("R1 in reset", outs(), 3'b110);
        job_req = 1'b0; grant_n = 1'b1;
        rst = 1'b0;
        tick(1);
        check("R1 after reset", outs(), 3'b110);
    endtask

    task automatic t_grab_and_release();
        job_req = 1'b1;
        tick(1);
        check("R2 request raised", outs(), 3'b010);
        grant_n = 1'b0;
        tick(3);
        check("R6 not yet claimed at edge 3", outs(), 3'b010);
        tick(1);
        check("R6 claim at edge 4 / R11", outs(), 3'b001);
        tick(1);
        check("R7 request dropped after claim", outs(), 3'b101);
        grant_n = 1'b1;
        tick(8);
        check("R7 ownership held w/o grant", outs(), 3'b101);
        job_req = 1'b0;
        tick(1);
        check("R8 release", outs(), 3'b110);
        tick(4);
        check("R8 stays idle", outs(), 3'b110);
    endtask

    task automatic t_no_grant();
        job_req = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            check("R3 waiting for grant", outs(), 3'b010);
        end
        job_req = 1'b0;
        tick(1);
        check("R10 withdraw from request", outs(), 3'b110);
        quiet_bus();
    endtask

    task automatic t_strobe_busy();
        addr_strobe_n = 1'b0;
        grant_n = 1'b0;
        job_req = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            check("R4 strobe active blocks claim", outs(), 3'b010);
        end
        addr_strobe_n = 1'b1;
        tick(2);
        check("R6 strobe clear, edge 2", outs(), 3'b010);
        tick(1);
        check("R6 strobe clear, claim edge 3", outs(), 3'b001);
        quiet_bus();
        check("R8 released after strobe test", outs(), 3'b110);
    endtask

    task automatic t_dack_and_rival();
        xfer_ack_n = 1'b0;
        rival_ack_n = 1'b0;
        grant_n = 1'b0;
        job_req = 1'b1;
        tick(10);
        check("R5 both busy", outs(), 3'b010);
        xfer_ack_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            check("R5 rival ack blocks claim", outs(), 3'b010);
        end
        xfer_ack_n = 1'b0;
        rival_ack_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            check("R5 transfer ack blocks claim", outs(), 3'b010);
        end
        xfer_ack_n = 1'b1;
        tick(3);
        check("R5 claim once all quiet", outs(), 3'b001);
        quiet_bus();
    endtask

    task automatic t_holdoff();
        grant_n = 1'b0;
        job_req = 1'b1;
        tick(6);
        check("R9 setup owned", outs(), 3'b101);
        job_req = 1'b0;
        tick(1);
        check("R9 release cycle", outs(), 3'b110);
        job_req = 1'b1;
        tick(1);
        check("R9 hold-off cycle 2", outs(), 3'b110);
        tick(1);
        check("R9 hold-off cycle 3", outs(), 3'b110);
        tick(1);
        check("R9 re-request after hold-off", outs(), 3'b010);
        grant_n = 1'b1;
        job_req = 1'b0;
        tick(1);
        check("R10 withdraw after re-request", outs(), 3'b110);
        quiet_bus();
    endtask

    task automatic t_abandon_waitfree();
        grant_n = 1'b0;
        addr_strobe_n = 1'b0;
        job_req = 1'b1;
        tick(6);
        check("R4 waiting on busy strobe", outs(), 3'b010);
        job_req = 1'b0;
        tick(1);
        check("R10 withdraw while waiting free", outs(), 3'b110);
        addr_strobe_n = 1'b1;
        tick(5);
        check("R10 no late claim", outs(), 3'b110);
        quiet_bus();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        quiet_bus();
        t_grab_and_release();
        t_no_grant();
        t_strobe_busy();
        t_dack_and_rival();
        t_holdoff();
        t_abandon_waitfree();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: bench did not finish, actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule